// File: doc/BRIEF.md
# Debounced Storage Clear Controller

This block erases the general-purpose storage bytes of a small timekeeping register file when a pushbutton-style clear input is held low long enough. It runs from the 32.768 kHz timebase. The clear input passes through a two-flop synchronizer, and a hold counter then measures how long it stays low. The count only advances while a status input reports that main supply is valid and the oscillator is running.

Once the hold time is reached, the controller takes over the register file's single write port. It steps an address counter through the 114 storage bytes, which sit at addresses 14 to 127, and writes 0xFF to each one, one byte per clock. A one-cycle done pulse follows the last write. The time and control registers below the storage window are never addressed by the sweep. While the sweep runs, writes arriving from the host bus are dropped. At all other times they pass straight through to the write port.

Top module: `ramclr_top`

## Requirements
- R1: After reset, clearBusy and clearDone are 0 and the write port carries the bus write inputs unchanged (memWrEn = busWrEn, memAddr = busAddr, memWrData = busWrData).
- R2: A clear writes 0xFF exactly once to every address from 14 to 127 (114 bytes), in ascending order, one write per clock, with clearBusy high for those 114 cycles.
- R3: A clear never writes addresses 0 to 13, so the time and control registers keep their contents.
- R4: A clear starts only after the synchronized clear input has been low for 4096 consecutive clock samples. A single high sample restarts the count.
- R5: The hold count advances only while sysOk is 1. A sample with sysOk at 0 restarts the count, and a clear starts only if sysOk was 1 at its final sample.
- R6: Holding the clear input low without a break starts at most one clear. The input must be seen high again before another clear can start.
- R7: clearDone is high for exactly one cycle, the cycle right after the last clear write, and stays 0 at all other times.
- R8: While clearBusy is 1, bus writes are ignored: the write port carries only clear traffic (data 0xFF), and bus data never reaches storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clearN | input | 1 | Active-low pushbutton clear request, asynchronous |
| sysOk | input | 1 | 1 when main supply is valid and the oscillator runs |
| busWrEn | input | 1 | Host write strobe |
| busAddr | input | 7 | Host write address |
| busWrData | input | 8 | Host write data |
| memWrEn | output | 1 | Register file write enable |
| memAddr | output | 7 | Register file write address |
| memWrData | output | 8 | Register file write data |
| clearBusy | output | 1 | High while the clear sweep runs |
| clearDone | output | 1 | One-cycle pulse after the last clear write |

## Verification
The assertions check these rules on every cycle:
- a sweep starts at address 14 and only after a valid-supply sample;
- the sweep steps by one address per cycle and stays inside the storage window;
- the data is 0xFF throughout the sweep, whatever the bus drives;
- the done pulse is one cycle long and follows the end of the sweep.

The hold duration, the restart on a glitch or a supply drop, the single clear per press, and the resulting register file contents can only be shown by the bench's scenarios. The bench does this with a model of the register file built from the observed writes.

// File: rtl/ramclr_pkg.sv
package ramclr_pkg;
  // Strobes from the control FSM to the address datapath
  typedef struct packed {
    logic load;   // load the first storage address
    logic step;   // advance the address and drive a clear write
  } clrStrobe_t;
endpackage

// File: rtl/ramclr_ctrl.sv
module ramclr_ctrl
  import ramclr_pkg::*;
#(
  parameter int HOLD_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clearN,
  input  logic       sysOk,
  input  logic       lastAddr,
  output clrStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  typedef enum logic {S_IDLE, S_CLEAR} state_t;

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] holdCnt;
  logic             armedQ;
  logic             doneQ;
  state_t           stateQ;
  logic             sampleLow;
  logic             holdOk;
  logic             trigger;

  // Two-flop synchronizer. It resets to the released (high) level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], clearN};
  end

  assign sampleLow = ~syncQ[1];
  assign holdOk    = sampleLow && sysOk;
  assign trigger   = holdOk && armedQ && (holdCnt == CNT_LAST) && (stateQ == S_IDLE);

  // Counts consecutive qualified low samples and saturates at the last value.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   holdCnt <= '0;
    else if (!holdOk)            holdCnt <= '0;
    else if (holdCnt != CNT_LAST) holdCnt <= holdCnt + 1'b1;
  end

  // Armed again only after a high sample, so one press gives one clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          armedQ <= 1'b0;
    else if (!sampleLow) armedQ <= 1'b1;
    else if (trigger)    armedQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        S_IDLE:  if (trigger) stateQ <= S_CLEAR;
        S_CLEAR: if (lastAddr) begin
          stateQ <= S_IDLE;
          doneQ  <= 1'b1;
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  assign strobe.load = trigger;
  assign strobe.step = (stateQ == S_CLEAR);
  assign busy        = (stateQ == S_CLEAR);
  assign done        = doneQ;
endmodule

// File: rtl/ramclr_datapath.sv
module ramclr_datapath
  import ramclr_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int FIRST_BYTE = 14,
  parameter int NUM_BYTES  = 114
) (
  input  logic              clk,
  input  logic              rstN,
  input  clrStrobe_t        strobe,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              lastAddr
);
  localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(FIRST_BYTE);
  localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(FIRST_BYTE + NUM_BYTES - 1);

  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            addrQ <= FIRST_A;
    else if (strobe.load) addrQ <= FIRST_A;
    else if (strobe.step) addrQ <= addrQ + 1'b1;
  end

  assign lastAddr = (addrQ == LAST_A);

  // The sweep owns the single write port; bus traffic is dropped meanwhile.
  always_comb begin
    if (strobe.step) begin
      memWrEn   = 1'b1;
      memAddr   = addrQ;
      memWrData = '1;
    end else begin
      memWrEn   = busWrEn;
      memAddr   = busAddr;
      memWrData = busWrData;
    end
  end
endmodule

// File: rtl/ramclr_top.sv
module ramclr_top
  import ramclr_pkg::*;
#(
  parameter int HOLD_CYCLES = 4096,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int FIRST_BYTE  = 14,
  parameter int NUM_BYTES   = 114
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearN,
  input  logic              sysOk,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              clearBusy,
  output logic              clearDone
);
  clrStrobe_t strobe;
  logic       lastAddr;

  ramclr_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clearN   (clearN),
    .sysOk    (sysOk),
    .lastAddr (lastAddr),
    .strobe   (strobe),
    .busy     (clearBusy),
    .done     (clearDone)
  );

  ramclr_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FIRST_BYTE(FIRST_BYTE), .NUM_BYTES(NUM_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .memWrEn   (memWrEn),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .lastAddr  (lastAddr)
  );
endmodule

// File: rtl/ramclr_checker.sv
module ramclr_checker #(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int FIRST_BYTE = 14,
  parameter int NUM_BYTES  = 114
) (
  input logic              clk,
  input logic              rstN,
  input logic              sysOk,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic              clearBusy,
  input logic              clearDone
);
  localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(FIRST_BYTE);
  localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(FIRST_BYTE + NUM_BYTES - 1);

  // R2: the sweep starts at the first storage byte
  p_start_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clearBusy) |-> (memAddr == FIRST_A));

  // R2: consecutive sweep writes step by one address
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    (clearBusy && $past(clearBusy)) |-> (memAddr == $past(memAddr) + 1'b1));

  // R3: the sweep stays inside the storage window
  p_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    clearBusy |-> (memWrEn && memAddr >= FIRST_A && memAddr <= LAST_A));

  // R5: a sweep starts only after a valid-supply sample
  p_sysok_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clearBusy) |-> $past(sysOk));

  // R7: done follows the end of the sweep at the last address
  p_done_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    clearDone |-> ($past(clearBusy) && !clearBusy && $past(memAddr) == LAST_A));

  // R7: done lasts one cycle
  p_done_once_r7: assert property (@(posedge clk) disable iff (!rstN)
    clearDone |=> !clearDone);

  // R8: bus data never reaches the port during the sweep
  p_bus_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    clearBusy |-> (memWrData == '1));
endmodule

bind ramclr_top ramclr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .FIRST_BYTE(FIRST_BYTE), .NUM_BYTES(NUM_BYTES)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .sysOk     (sysOk),
  .memWrEn   (memWrEn),
  .memAddr   (memAddr),
  .memWrData (memWrData),
  .clearBusy (clearBusy),
  .clearDone (clearDone)
);

// File: tb/test_ramclr_top.sv
module test_ramclr_top;
  localparam int HOLD = 4096;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clearN = 1'b1;
  logic       sysOk = 1'b1;
  logic       busWrEn = 1'b0;
  logic [6:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic       memWrEn;
  logic [6:0] memAddr;
  logic [7:0] memWrData;
  logic       clearBusy;
  logic       clearDone;

  int errors = 0;
  int checks = 0;
  int clearWrites = 0;
  int doneCount = 0;
  logic [7:0] mem [128];

  always #4 clk = ~clk;  // 125 MHz

  ramclr_top i_ramclr_top (
    .clk(clk), .rstN(rstN), .clearN(clearN), .sysOk(sysOk),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .clearBusy(clearBusy), .clearDone(clearDone)
  );

  // Register file model built from the observed write port
  always @(negedge clk) begin
    if (rstN) begin
      if (memWrEn) mem[memAddr] = memWrData;
      if (clearBusy) clearWrites++;
      if (clearDone) doneCount++;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic hold_low(input int n);
    @(negedge clk);
    clearN = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic release_btn();
    clearN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", clearBusy, 0, "busy after reset");
    check("R1", clearDone, 0, "done after reset");
    busWrEn = 1'b1; busAddr = 7'd3; busWrData = 8'h5A;
    #1;
    check("R1", {memWrEn, memAddr, memWrData}, {1'b1, 7'd3, 8'h5A}, "bus passthrough");
    @(negedge clk);
    busWrEn = 1'b0;
    bus_write(7'd20, 8'h11);
    check("R1", mem[20], 8'h11, "bus write stored");
  endtask

  task automatic t_short_press();
    int w0 = clearWrites;
    hold_low(HOLD - 50);
    check("R4", clearBusy, 0, "busy before hold time");
    release_btn();
    check("R4", clearWrites - w0, 0, "writes after short press");
    check("R4", mem[20], 8'h11, "storage kept after short press");
  endtask

  task automatic t_glitch();
    int w0 = clearWrites;
    hold_low(3000);
    clearN = 1'b1;
    repeat (3) @(negedge clk);
    hold_low(3000);
    release_btn();
    check("R4", clearWrites - w0, 0, "glitch restarts hold count");
  endtask

  task automatic t_sysok();
    int w0 = clearWrites;
    hold_low(3000);
    sysOk = 1'b0;
    repeat (3) @(negedge clk);
    sysOk = 1'b1;
    repeat (3000) @(negedge clk);
    check("R5", clearWrites - w0, 0, "supply drop restarts hold count");
    release_btn();
    sysOk = 1'b0;
    hold_low(HOLD + 100);
    check("R5", clearWrites - w0, 0, "no clear with supply invalid");
    sysOk = 1'b1;
    release_btn();
  endtask

  task automatic t_full_clear();
    int w0 = clearWrites;
    int d0 = doneCount;
    int badData = 0;
    int ctrlTouched = 0;
    @(negedge clk);
    clearN = 1'b0;
    repeat (HOLD - 5) @(negedge clk);
    check("R4", clearBusy, 0, "not busy just before hold time");
    while (!clearBusy) @(negedge clk);
    // bus write attempt during the sweep
    busWrEn = 1'b1; busAddr = 7'd5; busWrData = 8'h77;
    #1;
    check("R8", memWrData, 8'hFF, "bus data blocked during sweep");
    @(negedge clk);
    busWrEn = 1'b0;
    repeat (200) @(negedge clk);
    check("R2", clearWrites - w0, 114, "clear write count");
    check("R7", doneCount - d0, 1, "done pulses per clear");
    for (int a = 14; a < 128; a++) if (mem[a] != 8'hFF) badData++;
    check("R2", badData, 0, "storage bytes not 0xFF");
    check("R3", mem[3], 8'h5A, "control byte 3 kept");
    for (int a = 0; a < 14; a++) if (mem[a] == 8'hFF) ctrlTouched++;
    check("R3", ctrlTouched, 0, "control bytes set to 0xFF");
    check("R8", mem[5], 0, "blocked bus write not stored");
    // keep holding: no second clear
    repeat (HOLD + 200) @(negedge clk);
    check("R6", clearWrites - w0, 114, "continuous hold gives one clear");
    release_btn();
    bus_write(7'd40, 8'h22);
    hold_low(HOLD + 200);
    check("R6", clearWrites - w0, 228, "second press gives second clear");
    check("R6", mem[40], 8'hFF, "second clear overwrote byte 40");
    check("R7", doneCount - d0, 2, "done pulses after two clears");
    release_btn();
  endtask

  initial begin
    for (int a = 0; a < 128; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_short_press();
    t_glitch();
    t_sysok();
    t_full_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule